// File: doc/BRIEF.md
# Word-to-Halfword Memory Bridge

This bridge lets a host bus that only issues 32-bit slave accesses talk to a local memory port that is 16 bits wide. The host gives no dynamic sizing help, so the bridge hides the narrow memory completely. A host access carries a word address, four byte-lane enables, a write flag and write data. The bridge splits it into one or two local 16-bit cycles. For reads it gathers both halves into a full 32-bit word, and then it pulses an acknowledge back to the host.

Each host word maps onto two local halfwords. The half at local address `{word,0}` is always issued first, then the half at `{word,1}`. With `BIG_END=0`, local half 0 holds byte lanes 1:0 (bits 15:0) and half 1 holds lanes 3:2 (bits 31:16). `BIG_END=1` swaps the two pairs. A read always fetches both halves, whatever lanes were asked for. A write issues a local cycle only for a half whose lanes are enabled.

With `POSTED=1`, a write is acknowledged at once and drains in the background from a one-entry holding slot. With `POSTED=0`, the acknowledge waits until the last local cycle has retired. The local port is a request/grant interface, and read data returns a fixed `RD_LAT` cycles after the grant.

Top module: `hb_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, `host_ack` and `mem_req` are low.
- R2: A read issues exactly two local cycles, at `{addr,0}` and then `{addr,1}`. It returns all 32 bits of the word whatever `host_be` holds.
- R3: A write with all four lanes enabled issues two local cycles with mask `11`. Mask bit 1 enables bits 15:8 of the local half and mask bit 0 enables bits 7:0.
- R4: A write touching lanes of only one half issues exactly one local cycle at that half's address, with the matching 2-bit mask. A write with no lanes enabled issues no local cycle but is still acknowledged.
- R5: With the default `BIG_END=0`, local half 0 carries host bits 15:0 (lanes 1:0) and local half 1 carries host bits 31:16 (lanes 3:2).
- R6: In posted mode, a write is acknowledged in the cycle after the bridge first sees the request, before its local cycles complete.
- R7: While a posted write is draining, a new read or write is not acknowledged until the write has retired. A read of the same word therefore returns the newly written data, and a second write waits for the one-entry slot.
- R8: While `mem_req` is high and `mem_gnt` is low, the request and its address, mask, direction and data hold unchanged.
- R9: Read data is taken from `mem_rdata` exactly `RD_LAT` cycles after the grant cycle, one return per issued half. With grant always given, a read is acknowledged `4+RD_LAT` cycles after the cycle in which it was presented.
- R10: `host_ack` is a one-cycle pulse. The request still present in the acknowledge cycle is not taken again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host word address |
| host_be | input | 4 | Byte-lane enables, bit n = bits 8n+7:8n |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read word, valid with `host_ack` of a read |
| mem_req | output | 1 | Local cycle request |
| mem_we | output | 1 | Local cycle direction |
| mem_addr | output | ADDR_W+1 | Local halfword address |
| mem_wmask | output | 2 | Byte mask within the local half |
| mem_wdata | output | 16 | Local write data |
| mem_gnt | input | 1 | Local grant; a cycle happens when `mem_req` and `mem_gnt` are both high |
| mem_rdata | input | 16 | Local read data, `RD_LAT` cycles after the grant |

## Verification
On every cycle, the assertions check four things:
- the acknowledge is a single pulse;
- a request waiting for grant holds steady;
- a write cycle never goes out with an empty mask;
- a read is acknowledged only once both halves have returned, and no half comes back twice.

Only the bench scenarios can show the rest:
- that the right local addresses and masks follow from each lane pattern;
- that the gathered word matches the memory contents;
- that posted acknowledges arrive early;
- that a read placed right behind a posted write sees the new data.

// File: rtl/hb_pkg.sv
// Shared widths and types for the word-to-halfword bridge.
// Assumes a 32-bit host word split into two 16-bit local halves.
package hb_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int MASK_W = HALF_W / 8;

    // One local half-cycle worth of write information
    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [HALF_W-1:0] data;
    } hb_half_t;
endpackage

// File: rtl/hb_lane_plan.sv
// Maps host byte lanes onto the two local halves and reassembles read halves.
// Assumes local half 0 is issued first; BIG_END picks which lane pair it carries.
module hb_lane_plan
    import hb_pkg::*;
#(
    parameter bit BIG_END = 1'b0
) (
    input  logic [3:0]        be,
    input  logic [WORD_W-1:0] wdata,
    input  logic [HALF_W-1:0] rd0,
    input  logic [HALF_W-1:0] rd1,
    output hb_half_t          h0,
    output hb_half_t          h1,
    output logic [WORD_W-1:0] rword
);
    generate
        if (BIG_END) begin : g_big
            // half 0 carries upper lanes
            assign h0    = {be[3:2], wdata[WORD_W-1:HALF_W]};
            assign h1    = {be[1:0], wdata[HALF_W-1:0]};
            assign rword = {rd0, rd1};
        end else begin : g_little
            // half 0 carries lower lanes
            assign h0    = {be[1:0], wdata[HALF_W-1:0]};
            assign h1    = {be[3:2], wdata[WORD_W-1:HALF_W]};
            assign rword = {rd1, rd0};
        end
    endgenerate
endmodule

// File: rtl/hb_post_slot.sv
// One-entry holding slot for the active access plus its pending-half bits.
// Assumes take only occurs when the slot is idle.
module hb_post_slot
    import hb_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  hb_half_t          h0_in,
    input  hb_half_t          h1_in,
    input  logic              fire,
    input  logic              fire_idx,
    output logic              job_we,
    output logic [ADDR_W-1:0] job_addr,
    output hb_half_t          job_h0,
    output hb_half_t          job_h1,
    output logic [1:0]        pend
);
    // Latch a new access, then retire halves as they are granted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= '0;
            job_we   <= 1'b0;
            job_addr <= '0;
            job_h0   <= '0;
            job_h1   <= '0;
        end else if (take) begin
            job_we   <= we;
            job_addr <= addr;
            job_h0   <= h0_in;
            job_h1   <= h1_in;
            pend     <= we ? {|h1_in.mask, |h0_in.mask} : 2'b11;
        end else if (fire) begin
            pend[fire_idx] <= 1'b0;
        end
    end
endmodule

// File: rtl/hb_rd_gather.sv
// Tracks issued local reads through a fixed-latency pipe and captures each half.
// Assumes mem_rdata is valid exactly RD_LAT cycles after the grant cycle.
module hb_rd_gather
    import hb_pkg::*;
#(
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              issue,
    input  logic              idx,
    input  logic [HALF_W-1:0] mem_rdata,
    output logic [HALF_W-1:0] rd0,
    output logic [HALF_W-1:0] rd1,
    output logic [1:0]        got
);
    logic [RD_LAT-1:0] vpipe;
    logic [RD_LAT-1:0] ipipe;

    // Shift the issued-read markers toward the return point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpipe <= '0;
            ipipe <= '0;
        end else begin
            vpipe[0] <= issue;
            ipipe[0] <= idx;
            for (int i = 1; i < RD_LAT; i++) begin
                vpipe[i] <= vpipe[i-1];
                ipipe[i] <= ipipe[i-1];
            end
        end
    end

    // Capture each returning half into its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd0 <= '0;
            rd1 <= '0;
            got <= '0;
        end else if (clr) begin
            got <= '0;
        end else if (vpipe[RD_LAT-1]) begin
            got[ipipe[RD_LAT-1]] <= 1'b1;
            if (ipipe[RD_LAT-1]) rd1 <= mem_rdata;
            else                 rd0 <= mem_rdata;
        end
    end

    // R9: a half never returns twice for one access
    p_one_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vpipe[RD_LAT-1] |-> !got[ipipe[RD_LAT-1]])
        else $error("p_one_return_r9");
endmodule

// File: rtl/hb_bridge.sv
// Presents a 16-bit local memory as a 32-bit slave to a host without bus sizing.
// Assumes the host holds host_req and its fields stable until host_ack.
module hb_bridge
    import hb_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int RD_LAT  = 2,
    parameter bit BIG_END = 1'b0,
    parameter bit POSTED  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [3:0]        host_be,
    input  logic [31:0]       host_wdata,
    output logic              host_ack,
    output logic [31:0]       host_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W:0]   mem_addr,
    output logic [1:0]        mem_wmask,
    output logic [15:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [15:0]       mem_rdata
);
    localparam int LADDR_W = ADDR_W + 1;

    logic              busy;
    logic              take;
    logic              fire;
    logic              cur;
    hb_half_t          pl_h0, pl_h1, job_h0, job_h1;
    logic              job_we;
    logic [ADDR_W-1:0] job_addr;
    logic [1:0]        pend;
    logic [15:0]       rd0, rd1;
    logic [1:0]        got;

    // Take a request only when idle and not in the acknowledge cycle
    assign take = host_req && !busy && !host_ack;
    assign fire = mem_req && mem_gnt;
    assign cur  = !pend[0];

    hb_lane_plan #(.BIG_END(BIG_END)) u_plan (
        .be(host_be), .wdata(host_wdata), .rd0(rd0), .rd1(rd1),
        .h0(pl_h0), .h1(pl_h1), .rword(host_rdata)
    );

    hb_post_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .take(take), .we(host_we), .addr(host_addr),
        .h0_in(pl_h0), .h1_in(pl_h1), .fire(fire), .fire_idx(cur),
        .job_we(job_we), .job_addr(job_addr), .job_h0(job_h0), .job_h1(job_h1),
        .pend(pend)
    );

    hb_rd_gather #(.RD_LAT(RD_LAT)) u_gather (
        .clk(clk), .rst_n(rst_n), .clr(take), .issue(fire && !mem_we),
        .idx(cur), .mem_rdata(mem_rdata), .rd0(rd0), .rd1(rd1), .got(got)
    );

    // Drive the local port from the lowest pending half
    always_comb begin
        mem_req   = busy && (pend != 2'b00);
        mem_we    = job_we;
        mem_addr  = {job_addr, cur};
        mem_wmask = job_we ? (cur ? job_h1.mask : job_h0.mask) : 2'b11;
        mem_wdata = cur ? job_h1.data : job_h0.data;
    end

    // Sequence busy and acknowledge for posted writes, drained writes and reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            host_ack <= 1'b0;
        end else begin
            host_ack <= 1'b0;
            if (take) begin
                busy <= 1'b1;
                if (POSTED && host_we) host_ack <= 1'b1;
            end else if (busy && job_we && pend == 2'b00) begin
                busy <= 1'b0;
                if (!POSTED) host_ack <= 1'b1;
            end else if (busy && !job_we && got == 2'b11) begin
                busy     <= 1'b0;
                host_ack <= 1'b1;
            end
        end
    end

    // R10: acknowledge lasts one cycle
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack)
        else $error("p_ack_pulse_r10");

    // R8: an ungranted request holds steady
    p_hold_nogrant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wmask) && $stable(mem_wdata)))
        else $error("p_hold_nogrant_r8");

    // R4: no write cycle goes out with an empty mask
    p_mask_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wmask != 2'b00))
        else $error("p_mask_live_r4");

    // R2: a read completes only with both halves gathered
    p_read_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !job_we) |-> (got == 2'b11))
        else $error("p_read_full_r2");
endmodule

// File: tb/sim_hb_bridge.sv
module sim_hb_bridge;
    localparam int ADDR_W = 5;
    localparam int RD_LAT = 2;
    localparam int NWORD  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_req = 1'b0, host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [3:0]        host_be = '0;
    logic [31:0]       host_wdata = '0;
    logic              host_ack;
    logic [31:0]       host_rdata;
    logic              mem_req, mem_we, mem_gnt;
    logic [ADDR_W:0]   mem_addr;
    logic [1:0]        mem_wmask;
    logic [15:0]       mem_wdata, mem_rdata;
    logic              gnt_off = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;
    assign mem_gnt = !gnt_off;

    hb_bridge #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wmask(mem_wmask),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    // Local memory model with logging of every granted cycle
    logic [15:0]     mem16 [0:2*NWORD-1];
    logic [15:0]     rpipe [0:RD_LAT-1];
    logic [ADDR_W:0] log_addr [0:63];
    logic [1:0]      log_mask [0:63];
    int              log_n;
    assign mem_rdata = rpipe[RD_LAT-1];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2*NWORD; i++) mem16[i] <= 16'hA000 + 16'(i);
            for (int i = 0; i < RD_LAT; i++) rpipe[i] <= '0;
            log_n <= 0;
        end else begin
            rpipe[0] <= (mem_req && mem_gnt && !mem_we) ? mem16[mem_addr] : 16'h0;
            for (int i = 1; i < RD_LAT; i++) rpipe[i] <= rpipe[i-1];
            if (mem_req && mem_gnt) begin
                log_addr[log_n[5:0]] <= mem_addr;
                log_mask[log_n[5:0]] <= mem_wmask;
                log_n <= log_n + 1;
                if (mem_we) begin
                    if (mem_wmask[1]) mem16[mem_addr][15:8] <= mem_wdata[15:8];
                    if (mem_wmask[0]) mem16[mem_addr][7:0]  <= mem_wdata[7:0];
                end
            end
        end
    end

    // Bench word model built from the requirements (R5 lane mapping)
    logic [31:0] shadow [0:NWORD-1];

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic we, input logic [3:0] be,
                          input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int lat);
        host_req = 1'b1; host_we = we; host_be = be; host_addr = a; host_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_ack && lat < 300);
        rd = host_rdata;
        host_req = 1'b0;
        if (lat >= 300) chk(1'b0, "watchdog", 32'(lat), 32'd0);
        @(negedge clk);
        chk(!host_ack, "R10 ack pulse", {31'd0, host_ack}, 32'd0);
        if (we)
            for (int k = 0; k < 4; k++)
                if (be[k]) shadow[a][8*k +: 8] = d[8*k +: 8];
    endtask

    typedef struct packed {
        logic              we;
        logic [3:0]        be;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
        logic [1:0]        ncyc;
        logic [1:0]        mask0;
    } vec_t;

    localparam vec_t VEC [0:11] = '{
        '{1'b0, 4'hF, 5'd3,  32'h0,        2'd2, 2'b11},
        '{1'b1, 4'hF, 5'd3,  32'h11223344, 2'd2, 2'b11},
        '{1'b0, 4'h1, 5'd3,  32'h0,        2'd2, 2'b11},
        '{1'b1, 4'h4, 5'd5,  32'h00550000, 2'd1, 2'b01},
        '{1'b0, 4'hF, 5'd5,  32'h0,        2'd2, 2'b11},
        '{1'b1, 4'h3, 5'd6,  32'h0000BEEF, 2'd1, 2'b11},
        '{1'b1, 4'h8, 5'd7,  32'h9A000000, 2'd1, 2'b10},
        '{1'b0, 4'h2, 5'd7,  32'h0,        2'd2, 2'b11},
        '{1'b0, 4'hC, 5'd6,  32'h0,        2'd2, 2'b11},
        '{1'b1, 4'h0, 5'd9,  32'hFFFFFFFF, 2'd0, 2'b00},
        '{1'b0, 4'hF, 5'd9,  32'h0,        2'd2, 2'b11},
        '{1'b0, 4'hF, 5'd10, 32'h0,        2'd2, 2'b11}
    };

    initial begin
        logic [31:0] rd;
        int          lat, base, lat2;
        for (int w = 0; w < NWORD; w++)
            shadow[w] = {16'hA000 + 16'(2*w+1), 16'hA000 + 16'(2*w)};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!host_ack && !mem_req, "R1 reset", {30'd0, host_ack, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!host_ack && !mem_req, "R1 after reset", {30'd0, host_ack, mem_req}, 32'd0);

        // Table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < 12; i++) begin
            base = log_n;
            do_req(VEC[i].we, VEC[i].be, VEC[i].addr, VEC[i].data, rd, lat);
            if (VEC[i].we) begin
                chk(lat == 1, "R6 posted ack", 32'(lat), 32'd1);
                repeat (6) @(negedge clk);
            end else begin
                chk(rd == shadow[VEC[i].addr], "R2 R5 read word", rd, shadow[VEC[i].addr]);
                chk(lat == 4 + RD_LAT, "R9 read latency", 32'(lat), 32'(4 + RD_LAT));
            end
            chk(log_n - base == int'(VEC[i].ncyc), "R3 R4 local cycle count",
                32'(log_n - base), 32'(VEC[i].ncyc));
            if (VEC[i].ncyc != 0) begin
                chk(log_addr[base[5:0]] == {VEC[i].addr, VEC[i].we && VEC[i].be[1:0] == 2'b00},
                    "R2 R4 first local address", 32'(log_addr[base[5:0]]),
                    32'({VEC[i].addr, VEC[i].we && VEC[i].be[1:0] == 2'b00}));
                if (VEC[i].we)
                    chk(log_mask[base[5:0]] == VEC[i].mask0, "R3 R4 write mask",
                        32'(log_mask[base[5:0]]), 32'(VEC[i].mask0));
            end
        end

        // R7: read right behind a posted write stalls and sees the new data
        do_req(1'b1, 4'hF, 5'd12, 32'hCAFE0001, rd, lat);
        do_req(1'b0, 4'hF, 5'd12, 32'h0, rd, lat2);
        chk(rd == 32'hCAFE0001, "R7 read after posted write", rd, 32'hCAFE0001);
        chk(lat2 > 4 + RD_LAT, "R7 read stalled behind drain", 32'(lat2), 32'(5 + RD_LAT));
        // R7: second write waits for the one-entry slot
        do_req(1'b1, 4'hF, 5'd13, 32'h01020304, rd, lat);
        do_req(1'b1, 4'hF, 5'd13, 32'h05060708, rd, lat2);
        chk(lat2 > 1, "R7 second write held", 32'(lat2), 32'd2);
        do_req(1'b0, 4'hF, 5'd13, 32'h0, rd, lat);
        chk(rd == 32'h05060708, "R7 both writes retired in order", rd, 32'h05060708);

        // R8: request holds while grant is withheld
        gnt_off = 1'b1;
        host_req = 1'b1; host_we = 1'b0; host_be = 4'hF; host_addr = 5'd3;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            chk(mem_req && mem_addr == {5'd3, 1'b0}, "R8 hold without grant",
                {25'd0, mem_req, mem_addr}, {25'd0, 1'b1, 5'd3, 1'b0});
            @(negedge clk);
        end
        gnt_off = 1'b0;
        lat = 0;
        while (!host_ack && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        chk(host_rdata == shadow[3], "R8 read after grant stall", host_rdata, shadow[3]);
        host_req = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule